// File: doc/BRIEF.md
# Slotted Instruction Packet Sequencer

This block is the front end of a small stack processor. It reads 18-bit instruction packets from a synchronous memory whose read data is valid one cycle after the address is presented. It then hands the packet's 4-bit instructions, one at a time, to an external stack datapath. A packet either carries four short instructions or, when its 2-bit qualifier is non-zero, a 16-bit absolute target for a jump, a jump-on-zero or a call. An inline literal instruction takes its value from the memory word that follows the packet. A return instruction resumes at an address that the datapath supplies from its return stack.

The sequencer owns the program counter and the memory address mux. A load or a store takes its address from the datapath (`dp_addr`). The read or write data moves directly between the memory and the datapath. When the last useful instruction of a packet does not need the memory port, the fetch of the next packet overlaps with it. Trailing nops are skipped at no cost.

Top module: `psq_sequencer`

## Requirements
- R1: A packet is {qualifier[17:16], slot1[15:12], slot2[11:8], slot3[7:4], slot4[3:0]}. With qualifier 0, the non-nop slots are issued in order, slot1 first, one per cycle for stack opcodes 4 to E.
- R2: While reset is held, `pc` is 0, `issue_valid` is low, and a packet read of address 0 is presented (`mem_rd` high, `mem_addr` 0). The first packet executed after reset is the one at address 0.
- R3: When the last non-nop slot of a packet is a stack opcode (4 to E), the next packet's first instruction issues 2 cycles after it. Trailing nop slots add no cycles.
- R4: Opcode 0 (nop) is never issued. A nop followed by a non-nop in the same packet costs one idle cycle. A packet made only of nops adds 2 cycles, so the next issue comes 4 cycles after the previous one.
- R5: Store (opcode 3) issues in one cycle with `mem_we` high, `mem_addr` equal to `dp_addr` and no read. When it is the packet's last instruction, the next packet's first instruction issues 3 cycles later.
- R6: Literal (opcode 1) reads the word at the current `pc` and advances `pc`, so successive literals in one packet take successive words after the packet. It issues one cycle after the read, with the word on `lit_data`. Two literals in a row issue 2 cycles apart.
- R7: Load (opcode 2) issues with `mem_rd` high and `mem_addr` equal to `dp_addr`. The next slot issues 2 cycles later. When the load is the packet's last instruction, the next packet's first instruction issues 4 cycles later.
- R8: Qualifier 2 jumps unconditionally to slots 1 to 4 read as a 16-bit address. After any jump, call or return, a packet read is presented in the next cycle, and the rest of the current packet is discarded.
- R9: Qualifier 1 pulses `flag_pop` once. It jumps to the target when `zero_flag` is high and otherwise continues with the packet after it.
- R10: Qualifier 3 pulses `ret_push` with `ret_addr` equal to the address of the packet after the call, then jumps to the target. At most one of `ret_push`, `ret_pop`, `flag_pop` and `issue_valid` is high in any cycle.
- R11: Opcode F pulses `ret_pop` and continues by fetching the packet at `ret_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 18 | Memory address: the packet or literal address, or `dp_addr` for a load or store |
| mem_rd | output | 1 | Read strobe; the data is valid in the next cycle |
| mem_we | output | 1 | Write strobe for a store |
| mem_rdata | input | 18 | Read data from memory |
| pc | output | 16 | Program counter |
| issue_valid | output | 1 | An instruction is issued to the datapath this cycle |
| issue_op | output | 4 | Issued opcode |
| lit_data | output | 18 | Literal value, valid when opcode 1 is issued |
| zero_flag | input | 1 | The popped flag is zero (used by qualifier 1) |
| flag_pop | output | 1 | Pop the flag for a conditional jump |
| dp_addr | input | 18 | Load/store address from the datapath |
| ret_push | output | 1 | Push `ret_addr` onto the return stack |
| ret_addr | output | 16 | Return address for a call |
| ret_pop | output | 1 | Pop the return stack |
| ret_target | input | 16 | Top of the return stack |

## Verification
The hardest cases to reach are the cycle costs that depend on where a packet ends: overlapped fetch, trailing nops, all-nop packets, and a memory-using last slot. From the ports they show up only as the spacing between issues. The bench therefore stamps every observed event with its cycle and compares the gap to the previous event against hand-derived values. The programs lay out packets so that each ending shape occurs at least once. Call, return and both outcomes of the conditional jump are reached with a bench-side return stack and a flag that toggles on each pop.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_LOAD  = 3'd1,
    ST_EXEC  = 3'd2,
    ST_LIT   = 3'd3,
    ST_DWAIT = 3'd4
  } psq_state_e;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_LIT   = 4'h1;
  localparam logic [3:0] OP_LOAD  = 4'h2;
  localparam logic [3:0] OP_STORE = 4'h3;
  localparam logic [3:0] OP_RET   = 4'hF;

  localparam logic [1:0] Q_SEQ  = 2'd0;
  localparam logic [1:0] Q_JZ   = 2'd1;
  localparam logic [1:0] Q_JMP  = 2'd2;
  localparam logic [1:0] Q_CALL = 2'd3;

endpackage

// File: rtl/psq_rst_sync.sv
module psq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psq_slot_reg.sv
module psq_slot_reg #(
  parameter int WORD_W  = 18,
  parameter int SLOT_W  = 4,
  parameter int N_SLOTS = 4,
  localparam int PC_W   = SLOT_W * N_SLOTS,
  localparam int QUAL_W = WORD_W - PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  output logic [QUAL_W-1:0] qual,
  output logic [SLOT_W-1:0] head,
  output logic              tail_empty,
  output logic [PC_W-1:0]   target
);
  logic [QUAL_W-1:0] qual_q, qual_d;
  logic [SLOT_W-1:0] slot_q   [N_SLOTS];
  logic [SLOT_W-1:0] slot_d   [N_SLOTS];
  logic [SLOT_W-1:0] shift_in [N_SLOTS];

  // each slot takes its right neighbour on a shift, the last one takes a nop
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_fill
    if (g == N_SLOTS - 1) begin : g_last
      assign shift_in[g] = '0;
    end else begin : g_mid
      assign shift_in[g] = slot_q[g+1];
    end
  end

  always_comb begin
    qual_d = qual_q;
    for (int i = 0; i < N_SLOTS; i++) begin
      slot_d[i] = slot_q[i];
      if (load_en)       slot_d[i] = load_word[(N_SLOTS-1-i)*SLOT_W +: SLOT_W];
      else if (shift_en) slot_d[i] = shift_in[i];
    end
    if (load_en) qual_d = load_word[WORD_W-1 -: QUAL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= '0;
      for (int i = 0; i < N_SLOTS; i++) slot_q[i] <= '0;
    end else begin
      qual_q <= qual_d;
      for (int i = 0; i < N_SLOTS; i++) slot_q[i] <= slot_d[i];
    end
  end

  always_comb begin
    tail_empty = 1'b1;
    for (int i = 1; i < N_SLOTS; i++) begin
      if (slot_q[i] != '0) tail_empty = 1'b0;
    end
    for (int i = 0; i < N_SLOTS; i++) begin
      target[(N_SLOTS-1-i)*SLOT_W +: SLOT_W] = slot_q[i];
    end
  end

  assign qual = qual_q;
  assign head = slot_q[0];
endmodule

// File: rtl/psq_decode.sv
module psq_decode
  import psq_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int QUAL_W = 2
) (
  input  logic [QUAL_W-1:0] qual,
  input  logic [SLOT_W-1:0] head,
  input  logic              tail_empty,
  output logic              is_ctl,
  output logic              is_nop,
  output logic              is_lit,
  output logic              is_load,
  output logic              is_store,
  output logic              is_ret,
  output logic              can_overlap
);
  logic uses_mem;

  always_comb begin
    is_ctl   = (qual != '0);
    is_nop   = !is_ctl && (head == SLOT_W'(OP_NOP));
    is_lit   = !is_ctl && (head == SLOT_W'(OP_LIT));
    is_load  = !is_ctl && (head == SLOT_W'(OP_LOAD));
    is_store = !is_ctl && (head == SLOT_W'(OP_STORE));
    is_ret   = !is_ctl && (head == SLOT_W'(OP_RET));
    uses_mem = is_lit || is_load || is_store;
    // the port is free for the next packet when nothing else needs it
    can_overlap = tail_empty && !is_ctl && !is_ret && !uses_mem;
  end
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int SLOT_W = 4,
  parameter int PC_W   = 16,
  parameter int QUAL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QUAL_W-1:0] qual,
  input  logic [SLOT_W-1:0] head,
  input  logic              tail_empty,
  input  logic [PC_W-1:0]   target,
  input  logic              is_ctl,
  input  logic              is_nop,
  input  logic              is_lit,
  input  logic              is_load,
  input  logic              is_store,
  input  logic              is_ret,
  input  logic              can_overlap,
  input  logic              zero_flag,
  input  logic [PC_W-1:0]   ret_target,
  input  logic [WORD_W-1:0] dp_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              load_en,
  output logic              shift_en,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [PC_W-1:0]   pc,
  output logic              issue_valid,
  output logic [SLOT_W-1:0] issue_op,
  output logic [WORD_W-1:0] lit_data,
  output logic              flag_pop,
  output logic              ret_push,
  output logic [PC_W-1:0]   ret_addr,
  output logic              ret_pop
);
  localparam int PAD_W = WORD_W - PC_W;

  psq_state_e      state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    mem_addr    = {{PAD_W{1'b0}}, pc_q};
    mem_rd      = 1'b0;
    mem_we      = 1'b0;
    issue_valid = 1'b0;
    issue_op    = head;
    lit_data    = '0;
    load_en     = 1'b0;
    shift_en    = 1'b0;
    flag_pop    = 1'b0;
    ret_push    = 1'b0;
    ret_pop     = 1'b0;
    ret_addr    = pc_q;

    case (state_q)
      ST_FETCH: begin
        mem_rd  = 1'b1;
        state_d = ST_LOAD;
      end

      ST_LOAD: begin
        load_en = 1'b1;
        pc_d    = pc_inc;
        state_d = ST_EXEC;
      end

      ST_EXEC: begin
        if (is_ctl) begin
          state_d = ST_FETCH;
          case (qual)
            QUAL_W'(Q_JZ): begin
              flag_pop = 1'b1;
              if (zero_flag) pc_d = target;
            end
            QUAL_W'(Q_JMP): pc_d = target;
            default: begin
              ret_push = 1'b1;
              pc_d     = target;
            end
          endcase
        end else if (is_ret) begin
          ret_pop = 1'b1;
          pc_d    = ret_target;
          state_d = ST_FETCH;
        end else if (is_lit) begin
          mem_rd  = 1'b1;
          pc_d    = pc_inc;
          state_d = ST_LIT;
        end else if (is_load) begin
          issue_valid = 1'b1;
          mem_rd      = 1'b1;
          mem_addr    = dp_addr;
          state_d     = ST_DWAIT;
        end else begin
          if (is_store) begin
            mem_we   = 1'b1;
            mem_addr = dp_addr;
          end
          issue_valid = !is_nop;
          if (can_overlap) begin
            mem_rd  = 1'b1;
            state_d = ST_LOAD;
          end else if (tail_empty) begin
            state_d = ST_FETCH;
          end else begin
            shift_en = 1'b1;
          end
        end
      end

      ST_LIT: begin
        issue_valid = 1'b1;
        issue_op    = SLOT_W'(OP_LIT);
        lit_data    = mem_rdata;
        if (tail_empty) begin
          state_d = ST_FETCH;
        end else begin
          shift_en = 1'b1;
          state_d  = ST_EXEC;
        end
      end

      ST_DWAIT: begin
        if (tail_empty) begin
          state_d = ST_FETCH;
        end else begin
          shift_en = 1'b1;
          state_d  = ST_EXEC;
        end
      end

      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer #(
  parameter int WORD_W  = 18,
  parameter int SLOT_W  = 4,
  parameter int N_SLOTS = 4,
  localparam int PC_W   = SLOT_W * N_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc,
  output logic              issue_valid,
  output logic [SLOT_W-1:0] issue_op,
  output logic [WORD_W-1:0] lit_data,
  input  logic              zero_flag,
  output logic              flag_pop,
  input  logic [WORD_W-1:0] dp_addr,
  output logic              ret_push,
  output logic [PC_W-1:0]   ret_addr,
  output logic              ret_pop,
  input  logic [PC_W-1:0]   ret_target
);
  localparam int QUAL_W = WORD_W - PC_W;

  logic              rst_n_sync;
  logic              load_en, shift_en;
  logic [QUAL_W-1:0] qual;
  logic [SLOT_W-1:0] head;
  logic              tail_empty;
  logic [PC_W-1:0]   target;
  logic              is_ctl, is_nop, is_lit, is_load, is_store, is_ret, can_overlap;

  psq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  psq_slot_reg #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_en    (load_en),
    .load_word  (mem_rdata),
    .shift_en   (shift_en),
    .qual       (qual),
    .head       (head),
    .tail_empty (tail_empty),
    .target     (target)
  );

  psq_decode #(.SLOT_W(SLOT_W), .QUAL_W(QUAL_W)) u_dec (
    .qual        (qual),
    .head        (head),
    .tail_empty  (tail_empty),
    .is_ctl      (is_ctl),
    .is_nop      (is_nop),
    .is_lit      (is_lit),
    .is_load     (is_load),
    .is_store    (is_store),
    .is_ret      (is_ret),
    .can_overlap (can_overlap)
  );

  psq_ctrl #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .PC_W(PC_W), .QUAL_W(QUAL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .qual        (qual),
    .head        (head),
    .tail_empty  (tail_empty),
    .target      (target),
    .is_ctl      (is_ctl),
    .is_nop      (is_nop),
    .is_lit      (is_lit),
    .is_load     (is_load),
    .is_store    (is_store),
    .is_ret      (is_ret),
    .can_overlap (can_overlap),
    .zero_flag   (zero_flag),
    .ret_target  (ret_target),
    .dp_addr     (dp_addr),
    .mem_rdata   (mem_rdata),
    .load_en     (load_en),
    .shift_en    (shift_en),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .pc          (pc),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .lit_data    (lit_data),
    .flag_pop    (flag_pop),
    .ret_push    (ret_push),
    .ret_addr    (ret_addr),
    .ret_pop     (ret_pop)
  );
endmodule

// File: rtl/psq_sequencer_chk.sv
module psq_sequencer_chk #(
  parameter int WORD_W = 18,
  parameter int SLOT_W = 4,
  parameter int PC_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              issue_valid,
  input logic [SLOT_W-1:0] issue_op,
  input logic              flag_pop,
  input logic [WORD_W-1:0] dp_addr,
  input logic              ret_push,
  input logic              ret_pop
);
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == dp_addr) && !mem_rd); // R5

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_op == SLOT_W'(2)) |-> mem_rd && (mem_addr == dp_addr)); // R7

  AST_NO_NOP_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_op != '0)); // R4

  AST_FLUSH_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_push || ret_pop || flag_pop) |=> mem_rd && !issue_valid && !mem_we); // R8

  AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_push, ret_pop, flag_pop, issue_valid})); // R10

  AST_LIT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_op == SLOT_W'(1)) |-> $past(mem_rd) && !$past(issue_valid)); // R6
endmodule

bind psq_sequencer psq_sequencer_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .mem_we      (mem_we),
  .issue_valid (issue_valid),
  .issue_op    (issue_op),
  .flag_pop    (flag_pop),
  .dp_addr     (dp_addr),
  .ret_push    (ret_push),
  .ret_pop     (ret_pop)
);

// File: tb/psq_sequencer_tb.sv
module psq_sequencer_tb;
  localparam int K_OP = 1, K_LIT = 2, K_ST = 3, K_LD = 4, K_RPUSH = 5, K_RPOP = 6, K_FPOP = 7;
  localparam logic [17:0] DPA = 18'h20005;

  typedef struct {
    int          kind;
    logic [17:0] val;
    int          gap;
    string       req;
  } ev_t;

  logic        clk, rst_n;
  logic [17:0] mem_addr, mem_rdata, lit_data, dp_addr;
  logic        mem_rd, mem_we, issue_valid, zero_flag, flag_pop, ret_push, ret_pop;
  logic [15:0] pc, ret_addr, ret_target;
  logic [3:0]  issue_op;

  logic [17:0] mem [64];
  logic [15:0] rstk [8];
  int          rsp;
  logic        flag_tb;
  int          cyc, last_stamp, checks, errors;
  logic        mon_on, done;
  ev_t         exp_q[$];

  psq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pc(pc), .issue_valid(issue_valid), .issue_op(issue_op),
    .lit_data(lit_data), .zero_flag(zero_flag), .flag_pop(flag_pop), .dp_addr(dp_addr),
    .ret_push(ret_push), .ret_addr(ret_addr), .ret_pop(ret_pop), .ret_target(ret_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
  end

  // bench-side return stack and a flag that toggles on every pop
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp     <= 0;
      flag_tb <= 1'b1;
    end else begin
      if (ret_push) begin
        rstk[rsp] <= ret_addr;
        rsp       <= rsp + 1;
      end
      if (ret_pop)  rsp     <= rsp - 1;
      if (flag_pop) flag_tb <= ~flag_tb;
    end
  end
  assign ret_target = (rsp > 0) ? rstk[rsp-1] : 16'h0;
  assign zero_flag  = flag_tb;
  assign dp_addr    = DPA;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input int kind, input logic [17:0] val, input int gap, input string req);
    ev_t e;
    e.kind = kind; e.val = val; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [17:0] val);
    ev_t e;
    int  g;
    g = (last_stamp < 0) ? -1 : cyc - last_stamp;
    last_stamp = cyc;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", "unexpected event kind", 32'(kind), 32'(0));
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind && e.val == val, e.req, "event kind/value",
          {4'(kind), 10'h0, val}, {4'(e.kind), 10'h0, e.val});
    if (e.gap >= 0) check(g == e.gap, e.req, "cycle gap", 32'(g), 32'(e.gap));
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (issue_valid && issue_op == 4'h1) observe(K_LIT, lit_data);
      else if (issue_valid)                observe(K_OP, {14'h0, issue_op});
      if (mem_we)                          observe(K_ST, mem_addr);
      if (issue_valid && issue_op == 4'h2) observe(K_LD, mem_addr);
      if (ret_push)                        observe(K_RPUSH, {2'b0, ret_addr});
      if (ret_pop)                         observe(K_RPOP, 18'h0);
      if (flag_pop)                        observe(K_FPOP, 18'h0);
    end
  end

  task automatic start_prog();
    mon_on = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc == 16'h0, "R2", "pc in reset", 32'(pc), 32'h0);
    check(!issue_valid, "R2", "issue in reset", 32'(issue_valid), 32'h0);
    check(mem_rd && mem_addr == 18'h0, "R2", "reset fetch address", 32'(mem_addr), 32'h0);
    last_stamp = -1;
    mon_on     = 1'b1;
    rst_n      = 1'b1;
  endtask

  task automatic finish_prog(input string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (30) @(posedge clk);
    check(exp_q.size() == 0, req, "expected events left", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; mon_on = 1'b0; done = 1'b0;
    cyc = 0; checks = 0; errors = 0; last_stamp = -1;
    for (int i = 0; i < 64; i++) mem[i] = 18'h20000 | 18'(i); // self-jumps as filler

    // Program 1: issue order, overlap, nops, store, literal, load
    mem[0] = 18'h04567; mem[1] = 18'h08000; mem[2] = 18'h09300;
    mem[3] = 18'h0A0B0; mem[4] = 18'h00000; mem[5] = 18'h0C100;
    mem[6] = 18'h3ABCD; mem[7] = 18'h0D200; mem[8] = 18'h0E000;
    mem[9] = 18'h20009;
    push_exp(K_OP, 18'h4, -1, "R2");
    push_exp(K_OP, 18'h5, 1, "R1");
    push_exp(K_OP, 18'h6, 1, "R1");
    push_exp(K_OP, 18'h7, 1, "R1");
    push_exp(K_OP, 18'h8, 2, "R3");
    push_exp(K_OP, 18'h9, 2, "R3");   // trailing nops skipped
    push_exp(K_OP, 18'h3, 1, "R5");
    push_exp(K_ST, DPA, 0, "R5");
    push_exp(K_OP, 18'hA, 3, "R5");
    push_exp(K_OP, 18'hB, 2, "R4");   // interior nop
    push_exp(K_OP, 18'hC, 4, "R4");   // all-nop packet
    push_exp(K_LIT, 18'h3ABCD, 2, "R6");
    push_exp(K_OP, 18'hD, 3, "R6");
    push_exp(K_OP, 18'h2, 1, "R7");
    push_exp(K_LD, DPA, 0, "R7");
    push_exp(K_OP, 18'hE, 4, "R7");
    start_prog();
    finish_prog("R8");

    // Program 2: call, two literals, return, taken and untaken jump-on-zero
    for (int i = 0; i < 64; i++) mem[i] = 18'h20000 | 18'(i);
    mem[8'h00] = 18'h30010; mem[8'h01] = 18'h10020;
    mem[8'h10] = 18'h01140; mem[8'h11] = 18'h00111; mem[8'h12] = 18'h00222;
    mem[8'h13] = 18'h0F000;
    mem[8'h20] = 18'h05000; mem[8'h21] = 18'h10030;
    mem[8'h22] = 18'h06000; mem[8'h23] = 18'h20023;
    mem[8'h30] = 18'h07000;
    push_exp(K_RPUSH, 18'h1, -1, "R10");
    push_exp(K_LIT, 18'h111, 4, "R10");
    push_exp(K_LIT, 18'h222, 2, "R6");
    push_exp(K_OP, 18'h4, 1, "R6");
    push_exp(K_RPOP, 18'h0, 2, "R11");
    push_exp(K_FPOP, 18'h0, 3, "R11");  // resumed at the pushed address
    push_exp(K_OP, 18'h5, 3, "R9");     // taken
    push_exp(K_FPOP, 18'h0, 2, "R9");
    push_exp(K_OP, 18'h6, 3, "R9");     // not taken: falls through
    start_prog();
    finish_prog("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule